// File: doc/BRIEF.md
# Bit-Sliced Sixteen-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two 16-bit operands. It is made of identical one-bit slices. Each slice can invert either of its operand bits, then forms the AND, OR and XOR of the conditioned bits and a full-adder sum, and picks one of the four. The carry of each slice feeds the next slice up, and the carry of the top slice leaves the block.

A single opcode decoder sits outside the slices and is shared by all of them. It turns a 3-bit opcode into two invert controls, a carry-in for the lowest slice and a 2-bit output selector. Subtraction is the adder with operand B inverted and carry-in set. NOR is the AND path with both operands inverted. A user drives the operands and the opcode and reads the result in the same evaluation. No clock is involved.

Top module: `bitslice_alu`

## Requirements
- R1: Opcode 3'b000 gives result = a AND b, with no operand inverted and carry-in 0.
- R2: Opcode 3'b001 gives result = a OR b.
- R3: Opcode 3'b011 gives {carry_out, result} = a + b, computed as a 17-bit unsigned sum.
- R4: Opcode 3'b010 gives {carry_out, result} = a + (NOT b) + 1, computed in 17 bits. The result is a - b modulo 2^16, and carry_out is 1 exactly when a >= b unsigned.
- R5: Opcode 3'b100 gives result = a XOR b.
- R6: Opcode 3'b101 gives result = NOT(a OR b), which the slices form as (NOT a) AND (NOT b).
- R7: Opcodes 3'b110 and 3'b111 behave exactly like opcode 3'b000, both in result and in carry_out.
- R8: For the logic opcodes (000, 001, 100, 110, 111), carry_out is bit 16 of a + b with carry-in 0. For opcode 101 it is bit 16 of (NOT a) + (NOT b) with carry-in 0.
- R9: The carry ripples through every slice. For example 16'hFFFF + 16'h0001 under opcode 011 gives result 0 and carry_out 1, and 16'h0000 - 16'h0001 under opcode 010 gives 16'hFFFF with carry_out 0.
- R10: The outputs are a combinational function of the present inputs. They hold no state and respond to an input change in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| op_code | input | 3 | Operation select |
| alu_out | output | 16 | Selected result of the slices |
| carry_out | output | 1 | Carry from the top slice |

## Verification
The embedded assertions are immediate checks evaluated on settled combinational values. They assume every input bit is a known 0 or 1 and that the opcode is stable during evaluation. The stimulus drives only known values, and it changes inputs on the rising edge of the bench clock while results are compared on the falling edge, so every compared value has settled. The operands are random plus a set of carry-chain corner values, and all eight opcodes are covered, including the two unused ones.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W  = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_SUB = 3'b010,
    OPC_ADD = 3'b011,
    OPC_XOR = 3'b100,
    OPC_NOR = 3'b101,
    OPC_RS6 = 3'b110,
    OPC_RS7 = 3'b111
  } opcode_e;

  typedef enum logic [SEL_W-1:0] {
    PICK_AND = 2'b00,
    PICK_OR  = 2'b01,
    PICK_SUM = 2'b10,
    PICK_XOR = 2'b11
  } pick_e;

  typedef struct packed {
    logic  flip_a;
    logic  flip_b;
    logic  carry_seed;
    pick_e pick;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output slice_ctrl_t     ctrl
);

  always_comb begin
    ctrl = '{flip_a: 1'b0, flip_b: 1'b0, carry_seed: 1'b0, pick: PICK_AND};
    unique case (opcode_e'(op_code))
      OPC_OR:  ctrl.pick = PICK_OR;
      OPC_ADD: ctrl.pick = PICK_SUM;
      OPC_SUB: begin
        ctrl.pick       = PICK_SUM;
        ctrl.flip_b     = 1'b1;
        ctrl.carry_seed = 1'b1;
      end
      OPC_XOR: ctrl.pick = PICK_XOR;
      OPC_NOR: begin
        ctrl.pick   = PICK_AND;
        ctrl.flip_a = 1'b1;
        ctrl.flip_b = 1'b1;
      end
      default: ctrl.pick = PICK_AND;
    endcase
  end

  // Only subtraction may seed the carry chain (R4, R8)
  always_comb begin
    if (!$isunknown(op_code))
      assert_seed_only_sub_R4: assert (ctrl.carry_seed == (op_code == OPC_SUB));
  end

  // Operand A is flipped only for NOR (R6)
  always_comb begin
    if (!$isunknown(op_code))
      assert_flip_a_nor_R6: assert (ctrl.flip_a == (op_code == OPC_NOR));
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic bit_a,
  input  logic bit_b,
  input  logic carry_in,
  input  logic flip_a,
  input  logic flip_b,
  input  pick_e pick,
  output logic bit_out,
  output logic carry_nx
);

  logic ca, cb;
  logic g_and, g_or, g_xor, g_sum;

  // operand conditioning
  always_comb begin
    ca = flip_a ? ~bit_a : bit_a;
    cb = flip_b ? ~bit_b : bit_b;
  end

  // gate paths and full adder
  always_comb begin
    g_and    = ca & cb;
    g_or     = ca | cb;
    g_xor    = ca ^ cb;
    g_sum    = g_xor ^ carry_in;
    carry_nx = (ca & cb) | (ca & carry_in) | (cb & carry_in);
  end

  // output selector
  always_comb begin
    unique case (pick)
      PICK_AND: bit_out = g_and;
      PICK_OR:  bit_out = g_or;
      PICK_SUM: bit_out = g_sum;
      default:  bit_out = g_xor;
    endcase
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_code,
  output logic [WIDTH-1:0] alu_out,
  output logic             carry_out
);

  localparam int unsigned EXT_W = WIDTH + 1;

  slice_ctrl_t    ctrl;
  logic [WIDTH:0] chain;

  alu_op_decoder u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign chain[0] = ctrl.carry_seed;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    alu_bit_slice u_slice (
      .bit_a    (opnd_a[gi]),
      .bit_b    (opnd_b[gi]),
      .carry_in (chain[gi]),
      .flip_a   (ctrl.flip_a),
      .flip_b   (ctrl.flip_b),
      .pick     (ctrl.pick),
      .bit_out  (alu_out[gi]),
      .carry_nx (chain[gi+1])
    );
  end

  assign carry_out = chain[WIDTH];

  // End-to-end arithmetic relations across the slice chain
  logic [EXT_W-1:0] add_ref, sub_ref;
  always_comb begin
    add_ref = {1'b0, opnd_a} + {1'b0, opnd_b};
    sub_ref = {1'b0, opnd_a} + {1'b0, ~opnd_b} + EXT_W'(1);
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_code})) begin
      if (op_code == OPC_ADD)
        assert_add_chain_R3: assert ({carry_out, alu_out} == add_ref);
      if (op_code == OPC_SUB)
        assert_sub_chain_R4: assert ({carry_out, alu_out} == sub_ref);
      if (op_code == OPC_NOR)
        assert_nor_out_R6: assert (alu_out == ~(opnd_a | opnd_b));
      if (op_code == OPC_RS6 || op_code == OPC_RS7)
        assert_unused_and_R7: assert (alu_out == (opnd_a & opnd_b));
    end
  end

endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;

  localparam int unsigned W = 16;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i, b_i;
  logic [2:0]   op_i;
  logic [W-1:0] res_o;
  logic         co_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  typedef struct {
    logic [W:0]   exp;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    string        tag;
  } item_t;

  item_t sb_q[$];

  bitslice_alu #(.WIDTH(W)) u_dut (
    .opnd_a    (a_i),
    .opnd_b    (b_i),
    .op_code   (op_i),
    .alu_out   (res_o),
    .carry_out (co_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    case (op)
      3'b011: model = s;
      3'b010: model = {1'b0, a} + {1'b0, ~b} + 17'd1;
      3'b101: begin
        s = {1'b0, ~a} + {1'b0, ~b};
        model = {s[W], ~a & ~b};
      end
      3'b001: model = {s[W], a | b};
      3'b100: model = {s[W], a ^ b};
      default: model = {s[W], a & b};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000: tag_of = "R1/R8";
      3'b001: tag_of = "R2/R8";
      3'b011: tag_of = "R3";
      3'b010: tag_of = "R4";
      3'b100: tag_of = "R5/R8";
      3'b101: tag_of = "R6/R8";
      default: tag_of = "R7";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    item_t it;
    @(posedge clk);
    a_i  = a;
    b_i  = b;
    op_i = op;
    it.exp = model(op, a, b);
    it.a = a; it.b = b; it.op = op; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares on the falling edge, after inputs settle
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if ({co_o, res_o} !== it.exp) begin
        n_fail++;
        $display("FAIL %s op=%b a=%h b=%h actual={%b,%h} expected={%b,%h}",
                 it.tag, it.op, it.a, it.b, co_o, res_o, it.exp[W], it.exp[W-1:0]);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a_i = '0; b_i = '0; op_i = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-state check: zero operands, AND opcode (R1)
    n_run++;
    if ({co_o, res_o} !== 17'h0) begin
      n_fail++;
      $display("FAIL R1 reset state actual={%b,%h} expected={0,0000}", co_o, res_o);
    end
    rst_n = 1'b1;

    // carry chain corners (R9)
    drive(3'b011, 16'hFFFF, 16'h0001, "R9");
    drive(3'b010, 16'h0000, 16'h0001, "R9");
    drive(3'b010, 16'h1234, 16'h1234, "R4");
    drive(3'b011, 16'h8000, 16'h8000, "R3");
    drive(3'b011, 16'h7FFF, 16'h0001, "R9");
    drive(3'b101, 16'h0000, 16'h0000, "R6");
    drive(3'b101, 16'hF0F0, 16'h0F0F, "R6");
    drive(3'b000, 16'hFFFF, 16'hFFFF, "R8");
    drive(3'b110, 16'hA5A5, 16'hFFFF, "R7");
    drive(3'b111, 16'hFFFF, 16'h5A5A, "R7");
    // consecutive changes, one cycle each (R10)
    drive(3'b011, 16'h0001, 16'h0001, "R10");
    drive(3'b100, 16'h0001, 16'h0001, "R10");
    drive(3'b001, 16'h0001, 16'h0002, "R10");
    // random sweep over all opcodes
    for (int k = 0; k < 800; k++) begin
      logic [2:0] op;
      op = 3'(k % 8);
      drive(op, 16'($urandom), 16'($urandom), tag_of(op));
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule